// File: doc/BRIEF.md
# LFSR Sequence Self-Test Checker

This block decides whether a captured buffer of 64-bit words looks like the output of a known linear feedback shift register. After a start pulse it takes a seed, a feedback polynomial, a match goal and a loop limit. It then looks for successive LFSR values among the buffer words. For each value it counts every buffer word equal to that value and adds the count to a running total. It stops with a pass verdict as soon as the total reaches the goal. It stops with a fail verdict when the number of searches reaches the loop limit.

The buffer is outside the block and is read through a simple address/data port. The read data must be valid in the same cycle as the address. The buffer word at address zero is never used in a comparison, so a leading word that is not yet trustworthy cannot count as a match. One buffer word is compared per clock, so each search takes `DEPTH-1` cycles.

Top module: `lfsr_seq_checker`

## Requirements
- R1: After reset, `done`, `pass` and `fail` are low and `loops` is zero.
- R2: A search compares the expected value against buffer addresses 1 to `DEPTH-1`, one address per clock. The word at address 0 never contributes a match.
- R3: Every buffer word equal to the expected value adds one to the running match total, so duplicate words each count.
- R4: After each full search, the checker passes if the running total is greater than or equal to the goal. A goal of 0 passes after the first search. When the goal is met on the same search that reaches the limit, pass wins.
- R5: The next expected value is the current value shifted left by one bit (a zero enters at bit 0). If bit 63 of the current value was 1, the polynomial is then XORed into the result.
- R6: If the number of searches reaches the loop limit before the goal is met, the checker fails. A loop limit of 0 fails on the start edge itself, with `loops` equal to 0.
- R7: When the verdict is given, `loops` equals the number of searches completed.
- R8: `done` is high for exactly one cycle. For a nonzero limit, it rises `loops*(DEPTH-1)` cycles after the clock edge that accepts start.
- R9: With `done`, exactly one of `pass` or `fail` is high. That verdict holds until the next accepted start, which clears both.
- R10: A start pulse while a check is running is ignored. Seed, polynomial, goal and limit are captured when start is accepted, and later changes on those inputs do not affect the running check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted only while idle |
| seed | input | 64 | First expected value |
| poly | input | 64 | Feedback polynomial, XORed in on a carry out of bit 63 |
| goal | input | GOAL_W (8) | Match total needed to pass |
| loop_limit | input | LOOP_W (16) | Maximum number of searches |
| rd_addr | output | $clog2(DEPTH) (3) | Buffer read address |
| rd_data | input | 64 | Buffer word at `rd_addr`, valid in the same cycle |
| done | output | 1 | One-cycle pulse when a verdict is given |
| pass | output | 1 | Pass verdict, held until the next start |
| fail | output | 1 | Fail verdict, held until the next start |
| loops | output | LOOP_W (16) | Searches completed |

## Verification
Wrong internal state has three kinds of symptom at the ports:
- A bad scan address or a lost match shows up as a wrong verdict or a wrong `loops` value at the end of the run.
- A mis-stepped expected value also shows up as a wrong verdict or a wrong `loops` value at the end of the run.
- A control error shows up as `done` arriving off the `loops*(DEPTH-1)` schedule.

Every run is therefore judged on verdict, loop count and latency together. The bench sweeps the goal and the limit exhaustively over a fixed buffer, so any fault is seen within the first run that reaches the affected search. It also reads the state again in the cycle after `done`, to check that the verdict is held and that the pulse has ended.

// File: rtl/lfsr_chk_pkg.sv
package lfsr_chk_pkg;

    typedef enum logic {
        CHK_IDLE = 1'b0,
        CHK_SCAN = 1'b1
    } chk_state_e;

endpackage

// File: rtl/lfsr_chk_step.sv
// One Galois-style advance of the expected value.
module lfsr_chk_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] poly,
    output logic [W-1:0] nxt
);
    logic [W-1:0] tap_mask;

    // Feedback is keyed on the bit that leaves the register.
    assign tap_mask = {W{cur[W-1]}};

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            if (b == 0) begin : g_lsb
                assign nxt[b] = poly[b] & tap_mask[b];
            end else begin : g_upper
                assign nxt[b] = cur[b-1] ^ (poly[b] & tap_mask[b]);
            end
        end
    endgenerate
endmodule

// File: rtl/lfsr_chk_hit.sv
// Compares one buffer word and bumps a saturating match total.
module lfsr_chk_hit #(
    parameter int W     = 64,
    parameter int CNT_W = 9
) (
    input  logic [W-1:0]     word,
    input  logic [W-1:0]     expect_v,
    input  logic [CNT_W-1:0] count_in,
    output logic [CNT_W-1:0] count_out
);
    logic eq;
    logic at_max;

    assign eq     = (word == expect_v);
    assign at_max = &count_in;

    always_comb begin
        if (eq && !at_max) begin
            count_out = count_in + CNT_W'(1);
        end else begin
            count_out = count_in;
        end
    end
endmodule

// File: rtl/lfsr_seq_checker.sv
module lfsr_seq_checker
    import lfsr_chk_pkg::*;
#(
    parameter int W      = 64,
    parameter int DEPTH  = 8,
    parameter int GOAL_W = 8,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [W-1:0]      seed,
    input  logic [W-1:0]      poly,
    input  logic [GOAL_W-1:0] goal,
    input  logic [LOOP_W-1:0] loop_limit,
    output logic [$clog2(DEPTH)-1:0] rd_addr,
    input  logic [W-1:0]      rd_data,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [LOOP_W-1:0] loops
);
    localparam int AW    = $clog2(DEPTH);
    localparam int HIT_W = GOAL_W + 1;
    localparam logic [AW-1:0] FIRST_ADDR = AW'(1);
    localparam logic [AW-1:0] LAST_ADDR  = AW'(DEPTH - 1);

    typedef struct packed {
        chk_state_e        st;
        logic [AW-1:0]     addr;
        logic [W-1:0]      expect_v;
        logic [W-1:0]      poly;
        logic [GOAL_W-1:0] goal;
        logic [LOOP_W-1:0] limit;
        logic [HIT_W-1:0]  hits;
        logic [LOOP_W-1:0] loops;
        logic              done;
        logic              pass;
        logic              fail;
    } chk_regs_t;

    chk_regs_t r_d, r_q;

    logic [W-1:0]      step_out;
    logic [HIT_W-1:0]  hits_nxt;
    logic [LOOP_W-1:0] searches;
    logic              goal_met;
    logic              limit_hit;

    lfsr_chk_step #(.W(W)) u_step (
        .cur  (r_q.expect_v),
        .poly (r_q.poly),
        .nxt  (step_out)
    );

    lfsr_chk_hit #(.W(W), .CNT_W(HIT_W)) u_hit (
        .word      (rd_data),
        .expect_v  (r_q.expect_v),
        .count_in  (r_q.hits),
        .count_out (hits_nxt)
    );

    assign searches  = r_q.loops + LOOP_W'(1);
    assign goal_met  = (hits_nxt >= {1'b0, r_q.goal});
    assign limit_hit = (searches >= r_q.limit);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            CHK_IDLE: begin
                if (start) begin
                    r_d.pass     = 1'b0;
                    r_d.fail     = 1'b0;
                    r_d.loops    = '0;
                    r_d.hits     = '0;
                    r_d.addr     = FIRST_ADDR;
                    r_d.expect_v = seed;
                    r_d.poly     = poly;
                    r_d.goal     = goal;
                    r_d.limit    = loop_limit;
                    if (loop_limit == '0) begin
                        r_d.done = 1'b1;
                        r_d.fail = 1'b1;
                    end else begin
                        r_d.st = CHK_SCAN;
                    end
                end
            end
            CHK_SCAN: begin
                r_d.hits = hits_nxt;
                if (r_q.addr == LAST_ADDR) begin
                    r_d.loops = searches;
                    r_d.addr  = FIRST_ADDR;
                    if (goal_met) begin
                        r_d.done = 1'b1;
                        r_d.pass = 1'b1;
                        r_d.st   = CHK_IDLE;
                    end else if (limit_hit) begin
                        r_d.done = 1'b1;
                        r_d.fail = 1'b1;
                        r_d.st   = CHK_IDLE;
                    end else begin
                        r_d.expect_v = step_out;
                    end
                end else begin
                    r_d.addr = r_q.addr + AW'(1);
                end
            end
            default: r_d.st = CHK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: CHK_IDLE, addr: FIRST_ADDR, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr = r_q.addr;
    assign done    = r_q.done;
    assign pass    = r_q.pass;
    assign fail    = r_q.fail;
    assign loops   = r_q.loops;

    // R9: a verdict pulse carries exactly one outcome
    a_r9_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass != fail));

    // R9: outcomes never overlap
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    // R9: an idle block without start keeps its verdict and stays quiet
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CHK_IDLE && !start) |=> ($stable(pass) && $stable(fail) && !done));

    // R10: captured configuration is frozen while scanning
    a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CHK_SCAN) |=> ($stable(r_q.goal) && $stable(r_q.limit) && $stable(r_q.poly)));

    // R2: the scan never addresses slot zero
    a_r2_skip_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == CHK_SCAN) |-> (rd_addr != '0));

    // R7: the reported search count never exceeds the captured limit
    a_r7_loops_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (loops <= r_q.limit));
endmodule

// File: tb/lfsr_seq_checker_bench.sv
module lfsr_seq_checker_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int SPAN       = DEPTH - 1;
    localparam int WDOG_MAX   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] seed = '0;
    logic [63:0] poly = '0;
    logic [7:0]  goal = '0;
    logic [15:0] loop_limit = '0;
    logic [2:0]  rd_addr;
    logic [63:0] rd_data;
    logic        done, pass, fail;
    logic [15:0] loops;

    logic [63:0] mem [DEPTH];
    int vectors = 0;
    int miscompares = 0;
    int wdog = 0;

    assign rd_data = mem[rd_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    lfsr_seq_checker #(.W(64), .DEPTH(DEPTH), .GOAL_W(8), .LOOP_W(16)) u_lfsr_seq_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .poly(poly),
        .goal(goal), .loop_limit(loop_limit), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .pass(pass), .fail(fail), .loops(loops)
    );

    always @(posedge clk) begin
        wdog++;
        if (wdog > WDOG_MAX) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", wdog, WDOG_MAX);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] adv(input logic [63:0] v, input logic [63:0] p);
        adv = (v << 1) ^ (v[63] ? p : 64'd0);
    endfunction

    // Expected verdict from the requirements: R2 skip slot 0, R3 multiplicity,
    // R4 goal check after each search, R5 step, R6 limit.
    function automatic void model(input logic [63:0] s, input logic [63:0] p,
                                  input int g, input int lim,
                                  output bit ps, output int lp);
        int hits = 0;
        logic [63:0] v = s;
        ps = 1'b0;
        lp = 0;
        for (int i = 0; i < lim; i++) begin
            for (int a = 1; a < DEPTH; a++) if (mem[a] == v) hits++;
            lp = i + 1;
            if (hits >= g) begin
                ps = 1'b1;
                return;
            end
            v = adv(v, p);
        end
    endfunction

    task automatic run_case(input logic [63:0] s, input logic [63:0] p, input int g, input int lim,
                            input bit exp_pass, input int exp_loops, input int intrude, input string req);
        int cyc = 0;
        int maxc = lim * SPAN + 4;
        @(negedge clk);
        seed = s; poly = p; goal = 8'(g); loop_limit = 16'(lim);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!done) begin
            // R9: accepted start clears the previous verdict
            check(!pass && !fail, "R9 clear on start", {pass, fail}, 0);
        end
        while (!done && cyc < maxc) begin
            if (cyc == intrude) begin
                // R10: restart attempt with a config that would fail at once
                start = 1'b1; seed = ~s; goal = 8'd0; loop_limit = 16'd0; poly = ~p;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        check(done, {req, " done seen"}, done, 1);
        check(pass == exp_pass && fail == !exp_pass, {req, " verdict"}, {pass, fail}, {exp_pass, !exp_pass});
        check(loops == 16'(exp_loops), {req, " R7 loops"}, loops, exp_loops);
        check(cyc == exp_loops * SPAN, {req, " R8 latency"}, cyc, exp_loops * SPAN);
        @(negedge clk);
        check(!done, "R8 single pulse", done, 0);
        check(pass == exp_pass && fail == !exp_pass, "R9 held", {pass, fail}, {exp_pass, !exp_pass});
    endtask

    task automatic run_model(input logic [63:0] s, input logic [63:0] p, input int g, input int lim, input string req);
        bit ps;
        int lp;
        model(s, p, g, lim, ps, lp);
        run_case(s, p, g, lim, ps, lp, -1, req);
    endtask

    localparam logic [63:0] P0 = 64'h2000_0000_0000_00A3;
    localparam logic [63:0] S0 = 64'h8123_4567_89AB_CDEF;

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = 64'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done && !pass && !fail && loops == 0, "R1 reset", {done, pass, fail}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !pass && !fail && loops == 0, "R1 after release", {done, pass, fail}, 0);

        // R2: seed present only in slot 0 never matches
        for (int a = 0; a < DEPTH; a++) mem[a] = 64'h5555_0000_0000_0000 + 64'(a);
        mem[0] = S0;
        run_case(S0, P0, 1, 1, 1'b0, 1, -1, "R2 slot0 skipped");
        mem[DEPTH-1] = S0;
        run_case(S0, P0, 1, 1, 1'b1, 1, -1, "R2 last slot used");

        // R3: duplicates each count
        for (int a = 1; a < DEPTH; a++) mem[a] = S0;
        run_case(S0, P0, 7, 1, 1'b1, 1, -1, "R3 seven copies");
        run_case(S0, P0, 8, 1, 1'b0, 1, -1, "R3 short by one");

        // R4: goal zero passes after first search; pass beats limit
        run_case(S0, P0, 0, 3, 1'b1, 1, -1, "R4 goal zero");
        // R6: limit zero fails at once
        run_case(S0, P0, 0, 0, 1'b0, 0, -1, "R6 limit zero");

        // R5: bit 63 set -> shift then XOR polynomial
        for (int a = 0; a < DEPTH; a++) mem[a] = 64'h0;
        mem[3] = (S0 << 1) ^ P0;
        run_case(S0, P0, 1, 2, 1'b1, 2, -1, "R5 feedback applied");
        mem[3] = S0 << 1;
        run_case(S0, P0, 1, 2, 1'b0, 2, -1, "R5 plain shift rejected");
        // bit 63 clear -> plain shift
        mem[3] = 64'h0246_8ACF_1357_9BDE;
        run_case(64'h0123_4567_89AB_CDEF, P0, 1, 2, 1'b1, 2, -1, "R5 no feedback");

        // R10: start while busy ignored
        for (int a = 0; a < DEPTH; a++) mem[a] = 64'hDEAD_0000_0000_0000 + 64'(a);
        run_case(S0, P0, 200, 5, 1'b0, 5, 3, "R10 busy start");

        // Sweep goal x limit over a buffer holding a stretch of the sequence
        begin
            logic [63:0] v = S0;
            mem[0] = S0;
            for (int a = 1; a < DEPTH; a++) begin
                v = adv(v, P0);
                mem[a] = v;
            end
            mem[5] = mem[2];
        end
        for (int g = 0; g <= 8; g++) begin
            for (int lim = 0; lim <= 9; lim++) begin
                run_model(S0, P0, g, lim, "R4 R6 sweep");
            end
        end
        for (int g = 0; g <= 4; g++) begin
            run_model(adv(S0, P0), P0, g, 6, "R3 R5 sweep shifted seed");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule